// File: doc/BRIEF.md
# Lockable low-power entry gate

This block sits between a processor's stop and wait requests and the logic that actually places the chip in a low-power mode. A memory-mapped control word holds one 2-bit field for stop and one for wait. In each field, the low bit chooses whether a request is honoured. The high bit is a self-lock that freezes the field against any further software writes until the next system reset.

Software normally programs each field once, early in boot. It can then set the lock bit in that same write, so that errant code cannot later enable or disable low-power entry. The processor raises a one-cycle stop or wait request. When the matching field allows entry, the block answers with a one-cycle entry pulse on the following clock edge. Clock gating, wake-up and power sequencing take over from that pulse and are handled elsewhere.

Top module: `lp_entry_gate`

## Requirements
- R1: After reset both fields are 00 (entry allowed, unlocked), the control word reads as zero and both entry outputs are low.
- R2: The control word at address CTRL_ADDR reads back the stop field in bits 3:2 and the wait field in bits 1:0. All other bits, and every other address, read as zero.
- R3: A stop request sampled while stop field bit 0 (word bit 2) is 0 produces a stop entry pulse one cycle high, registered at that same clock edge.
- R4: A stop request sampled while stop field bit 0 is 1 produces no stop entry pulse.
- R5: A wait request produces a wait entry pulse exactly when wait field bit 0 (word bit 0) is 0, with the same timing as R3.
- R6: A write to an unlocked field loads both of its bits at once. A write that sets field bit 1 (stop: word bit 3, wait: word bit 1) locks the field. Any later write leaves the field unchanged, whatever the value of bit 0.
- R7: The two fields lock independently. Locking one field does not stop writes to the other.
- R8: Writes to any address other than CTRL_ADDR change neither field.
- R9: Reset clears both locks and returns both fields to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for write and read |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| stop_req | input | 1 | Processor stop request pulse |
| wait_req | input | 1 | Processor wait request pulse |
| stop_go | output | 1 | Stop mode entry pulse |
| wait_go | output | 1 | Wait mode entry pulse |

## Verification
A register write takes effect at the clock edge that samples it. Read data is combinational, so the bench reads back a field half a cycle after the write edge. An entry pulse is registered on the edge that samples the request. The bench therefore checks it at the falling edge just after that edge, and checks the output low one cycle later to confirm the pulse width. All inputs change and all outputs are sampled on falling edges, well away from the active edge.

// File: rtl/lp_entry_gate.sv
module lp_entry_gate #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              stop_req,
  input  logic              wait_req,
  output logic              stop_go,
  output logic              wait_go
);

  localparam int FLD_W = 2;
  localparam int STOP_LSB = 2;
  localparam int WAIT_LSB = 0;

  logic [FLD_W-1:0] stop_f, wait_f;
  logic             hit;

  assign hit = reg_wr && (reg_addr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_f <= '0;
      wait_f <= '0;
    end else if (hit) begin
      if (!stop_f[1]) stop_f <= reg_wdata[STOP_LSB +: FLD_W];
      if (!wait_f[1]) wait_f <= reg_wdata[WAIT_LSB +: FLD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_go <= 1'b0;
      wait_go <= 1'b0;
    end else begin
      stop_go <= stop_req && !stop_f[0];
      wait_go <= wait_req && !wait_f[0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_ADDR) begin
      reg_rdata[STOP_LSB +: FLD_W] = stop_f;
      reg_rdata[WAIT_LSB +: FLD_W] = wait_f;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (stop_f == '0 && wait_f == '0 && !stop_go && !wait_go));

  assert_stop_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_go |-> $past(stop_req));

  assert_stop_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && stop_f[0]) |=> !stop_go);

  assert_wait_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wait_go |-> $past(wait_req));

  assert_stop_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_f[1] |=> $stable(stop_f));

  assert_wait_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wait_f[1] |=> $stable(wait_f));

  assert_foreign_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(stop_f) && $stable(wait_f)));

endmodule

// File: tb/lp_entry_gate_tb.sv
module lp_entry_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic stop_req = 1'b0, wait_req = 1'b0, stop_go, wait_go;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lp_entry_gate #(.ADDR_W(AW), .DATA_W(DW), .CTRL_ADDR('0)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stop_req(stop_req),
    .wait_req(wait_req), .stop_go(stop_go), .wait_go(wait_go));

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a, logic [DW-1:0] exp);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
    reg_addr = '0;
  endtask

  task automatic pulse(bit is_stop, bit exp_go, string req);
    @(negedge clk);
    if (is_stop) stop_req = 1'b1; else wait_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0; wait_req = 1'b0;
    chk(req, is_stop ? stop_go : wait_go, exp_go);
    chk(req, is_stop ? wait_go : stop_go, 1'b0);
    @(negedge clk);
    chk({req, " width"}, {stop_go, wait_go}, 2'b00);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 word", reg_rdata, '0);
    chk("R1 outs", {stop_go, wait_go}, 2'b00);
    pulse(1, 1, "R1 stop allowed");
    pulse(0, 1, "R1 wait allowed");
  endtask

  task automatic t_layout();
    do_reset();
    wr('0, 16'hFFF5);
    rd_chk("R2 layout", '0, 16'h0005);
    rd_chk("R2 other addr", 4'h3, '0);
  endtask

  task automatic t_stop();
    do_reset();
    pulse(1, 1, "R3 stop enter");
    wr('0, 16'h0004);
    pulse(1, 0, "R4 stop blocked");
    pulse(0, 1, "R4 wait unaffected");
    wr('0, 16'h0000);
    pulse(1, 1, "R3 stop re-enabled");
  endtask

  task automatic t_wait();
    do_reset();
    wr('0, 16'h0001);
    pulse(0, 0, "R5 wait blocked");
    pulse(1, 1, "R5 stop unaffected");
    wr('0, 16'h0000);
    pulse(0, 1, "R5 wait enter");
  endtask

  task automatic t_lock();
    do_reset();
    wr('0, 16'h000C);
    rd_chk("R6 lock write", '0, 16'h000C);
    pulse(1, 0, "R6 locked blocked");
    wr('0, 16'h0000);
    rd_chk("R6 ignored write", '0, 16'h000C);
    pulse(1, 0, "R6 still blocked");
    wr('0, 16'h0001);
    rd_chk("R7 wait still writable", '0, 16'h000D);
    wr('0, 16'h0002);
    rd_chk("R7 wait locks alone", '0, 16'h000E);
    wr('0, 16'h0003);
    rd_chk("R6 wait locked", '0, 16'h000E);
    pulse(0, 1, "R6 wait locked allowed");
  endtask

  task automatic t_foreign();
    do_reset();
    wr(4'h5, 16'h000F);
    rd_chk("R8 foreign write", '0, '0);
    pulse(1, 1, "R8 stop still allowed");
  endtask

  task automatic t_relock();
    do_reset();
    wr('0, 16'h000F);
    rd_chk("R9 pre", '0, 16'h000F);
    do_reset();
    rd_chk("R9 cleared", '0, '0);
    wr('0, 16'h0005);
    rd_chk("R9 writable again", '0, 16'h0005);
  endtask

  initial begin
    t_reset();
    t_layout();
    t_stop();
    t_wait();
    t_lock();
    t_foreign();
    t_relock();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule